// File: doc/BRIEF.md
# Microcode Program Sequencer

This block owns the program counter of a pipelined, horizontally microcoded signal processor. Every machine cycle it presents a program-memory fetch address and says whether the current cycle is a bubble. It handles the flow-control field of the instruction word: unconditional and flag-conditioned branches, subroutine call and return through a small hardware stack, a counted hardware loop that costs no cycles on loop-back, and an end-of-frame instruction that parks the processor until the next audio frame starts. The arithmetic fields and the program memory itself belong to other blocks.

The instruction word for the address on `fetch_addr_o` is presented on `op_i`, `target_i` and `loop_cnt_i` in the same cycle, together with the ALU flags. A one-cycle `frame_start_i` pulse marks the rising edge of the frame clock. The address space is sized by `ADDR_W` (default 9 bits, 512 steps), which holds a 383-step or 511-step frame program.

Top module: `seqctl_sequencer`

## Requirements
- R1: After a synchronous reset `fetch_addr_o` is 0, `nop_o` is 0 and `stack_err_o` is 0.
- R2: An instruction whose flow code is 0 (plain step) or an unused code (14, 15) advances the address by one, modulo 2^ADDR_W, with no bubble.
- R3: Code 1 (jump): the next cycle shows `nop_o`=1 with `fetch_addr_o` equal to `target_i`; the cycle after that executes the target.
- R4: Conditional jumps take codes 2 (sign or zero), 3 (sign), 4 (not sign), 5 (neither sign nor zero), 6 (zero), 7 (not zero), 8 (overflow), 9 (not overflow), evaluated on `sgf_i`, `zrf_i`, `ovf_i`; when taken they behave as R3, otherwise as R2 with no bubble.
- R5: Code 10 (call) saves the address after the call on the stack and then behaves as R3.
- R6: Code 11 (return) moves to the most recently saved address with no bubble.
- R7: The stack holds 4 addresses. A call with a full stack drops the save but still jumps; a return with an empty stack advances by one; either sets `stack_err_o`, which stays 1 until reset.
- R8: Code 12 (loop) with count N in `loop_cnt_i` and end address in `target_i` advances by one and makes the body from the next address to the end address run N times (N of 0 or 1 means once); a plain step at the end address returns to the body start with no bubble while repeats remain.
- R9: Code 13 (end) holds `nop_o`=1 and the address from the next cycle on until a cycle with `frame_start_i`=1; the cycle after that fetches address 0 without a bubble and cancels any loop. A frame pulse outside this wait is ignored.
- R10: During any cycle with `nop_o`=1 the instruction inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Flow-control code of the instruction at the fetch address |
| target_i | input | ADDR_W | Branch, call or loop-end address |
| loop_cnt_i | input | 5 | Loop count for code 12 |
| sgf_i | input | 1 | ALU sign flag |
| zrf_i | input | 1 | ALU zero flag |
| ovf_i | input | 1 | ALU overflow flag |
| frame_start_i | input | 1 | One-cycle pulse at the frame clock rising edge |
| fetch_addr_o | output | ADDR_W | Program-memory fetch address |
| nop_o | output | 1 | Current cycle is an inserted bubble |
| stack_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The assertions assume the instruction fields describe the word at `fetch_addr_o` in the same cycle and that `frame_start_i` is a single-cycle pulse; they hold regardless of the values on the instruction inputs during bubble cycles. The bench keeps to this by reading its program image at the current fetch address each cycle, and it deliberately drives unrelated random codes while a bubble is shown to exercise R10. Frame pulses arrive periodically, so some land outside an end wait and some inside it.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    typedef enum logic [3:0] {
        FOP_STEP = 4'd0,
        FOP_JMP  = 4'd1,
        FOP_JLE  = 4'd2,
        FOP_JLS  = 4'd3,
        FOP_JGE  = 4'd4,
        FOP_JGR  = 4'd5,
        FOP_JZR  = 4'd6,
        FOP_JNZ  = 4'd7,
        FOP_JOV  = 4'd8,
        FOP_JNO  = 4'd9,
        FOP_CALL = 4'd10,
        FOP_RET  = 4'd11,
        FOP_LOOP = 4'd12,
        FOP_END  = 4'd13
    } flow_op_e;

    typedef struct packed {
        logic sgf;
        logic zrf;
        logic ovf;
    } alu_flags_t;

    localparam int LOOP_CW = 5;

    function automatic logic op_is_cond(input logic [3:0] code);
        return (code >= 4'd2) && (code <= 4'd9);
    endfunction

    function automatic logic cond_met(input logic [3:0] code, input alu_flags_t f);
        logic r;
        case (code)
            4'd2:    r = f.sgf | f.zrf;
            4'd3:    r = f.sgf;
            4'd4:    r = ~f.sgf;
            4'd5:    r = ~f.sgf & ~f.zrf;
            4'd6:    r = f.zrf;
            4'd7:    r = ~f.zrf;
            4'd8:    r = f.ovf;
            4'd9:    r = ~f.ovf;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seqctl_cond.sv
module seqctl_cond
    import seqctl_pkg::*;
(
    input  logic [3:0]  code_i,
    input  alu_flags_t  flags_i,
    output logic        is_cond_o,
    output logic        taken_o
);
    always_comb begin
        is_cond_o = op_is_cond(code_i);
        taken_o   = is_cond_o && cond_met(code_i, flags_i);
    end
endmodule

// File: rtl/seqctl_stack.sv
module seqctl_stack #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    output logic [ADDR_W-1:0] top_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              err_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic              err_q;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign err_o   = err_q;

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i + 1) == cnt_q) top_o = mem_q[i];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) mem_q[g] <= '0;
                else if (push_i && !full_o && cnt_q == CNT_W'(g)) mem_q[g] <= push_addr_i;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (push_i) begin
                if (full_o) err_q <= 1'b1;
                else        cnt_q <= cnt_q + 1'b1;
            end else if (pop_i) begin
                if (empty_o) err_q <= 1'b1;
                else         cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R7: a push on a full stack raises the error flag
    a_r7_overflow_flag: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o) |=> err_o);
    // R7: a pop on an empty stack raises the error flag
    a_r7_underflow_flag: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && empty_o) |=> err_o);
    // R7: the error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
    // R5/R6: a saved address is what a following pop sees
    a_r5_push_top: assert property (@(posedge clk) disable iff (rst)
        (push_i && !full_o) |=> (top_o == $past(push_addr_i)));
endmodule

// File: rtl/seqctl_loop.sv
module seqctl_loop #(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] arm_start_i,
    input  logic [ADDR_W-1:0] arm_end_i,
    input  logic [CNT_W-1:0]  arm_cnt_i,
    input  logic              clear_i,
    input  logic              seq_step_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              back_o,
    output logic [ADDR_W-1:0] back_addr_o
);
    logic              act_q;
    logic [ADDR_W-1:0] start_q, end_q;
    logic [CNT_W-1:0]  rem_q;
    logic              at_end;

    assign at_end      = act_q && (pc_i == end_q);
    assign back_o      = at_end && (rem_q != '0);
    assign back_addr_o = start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            start_q <= '0;
            end_q   <= '0;
            rem_q   <= '0;
        end else if (clear_i) begin
            act_q <= 1'b0;
        end else if (arm_i) begin
            act_q   <= (arm_cnt_i > CNT_W'(1));
            start_q <= arm_start_i;
            end_q   <= arm_end_i;
            rem_q   <= (arm_cnt_i == '0) ? '0 : arm_cnt_i - 1'b1;
        end else if (seq_step_i && at_end) begin
            if (rem_q != '0) rem_q <= rem_q - 1'b1;
            else             act_q <= 1'b0;
        end
    end

    // R8: the repeat count only falls while the loop is running
    a_r8_rem_falls: assert property (@(posedge clk) disable iff (rst)
        (seq_step_i && back_o && !arm_i && !clear_i) |=> (rem_q == $past(rem_q) - 1'b1));
endmodule

// File: rtl/seqctl_sequencer.sv
module seqctl_sequencer
    import seqctl_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [4:0]        loop_cnt_i,
    input  logic              sgf_i,
    input  logic              zrf_i,
    input  logic              ovf_i,
    input  logic              frame_start_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              nop_o,
    output logic              stack_err_o
);
    logic [ADDR_W-1:0] pc_q, pc_d, pc_inc;
    logic              bub_q, bub_d, wait_q, wait_d;
    logic              exec;
    alu_flags_t        flags;
    logic              is_cond, taken;
    logic              push, pop, arm, seq_step, clear;
    logic [ADDR_W-1:0] stk_top;
    logic              stk_empty, stk_full;
    logic              loop_back;
    logic [ADDR_W-1:0] loop_addr;

    assign flags  = '{sgf: sgf_i, zrf: zrf_i, ovf: ovf_i};
    assign exec   = !bub_q && !wait_q;
    assign pc_inc = pc_q + 1'b1;

    seqctl_cond u_cond (
        .code_i    (op_i),
        .flags_i   (flags),
        .is_cond_o (is_cond),
        .taken_o   (taken)
    );

    seqctl_stack #(.DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W)) u_stack (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push),
        .pop_i       (pop),
        .push_addr_i (pc_inc),
        .top_o       (stk_top),
        .empty_o     (stk_empty),
        .full_o      (stk_full),
        .err_o       (stack_err_o)
    );

    seqctl_loop #(.ADDR_W(ADDR_W), .CNT_W(LOOP_CW)) u_loop (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm),
        .arm_start_i (pc_inc),
        .arm_end_i   (target_i),
        .arm_cnt_i   (loop_cnt_i),
        .clear_i     (clear),
        .seq_step_i  (seq_step),
        .pc_i        (pc_q),
        .back_o      (loop_back),
        .back_addr_o (loop_addr)
    );

    always_comb begin
        pc_d     = pc_q;
        bub_d    = 1'b0;
        wait_d   = wait_q;
        push     = 1'b0;
        pop      = 1'b0;
        arm      = 1'b0;
        seq_step = 1'b0;
        clear    = 1'b0;
        if (wait_q) begin
            if (frame_start_i) begin
                pc_d   = '0;
                wait_d = 1'b0;
                clear  = 1'b1;
            end
        end else if (!bub_q) begin
            if (is_cond) begin
                if (taken) begin
                    pc_d  = target_i;
                    bub_d = 1'b1;
                end else begin
                    seq_step = 1'b1;
                end
            end else begin
                case (op_i)
                    FOP_JMP: begin
                        pc_d  = target_i;
                        bub_d = 1'b1;
                    end
                    FOP_CALL: begin
                        push  = 1'b1;
                        pc_d  = target_i;
                        bub_d = 1'b1;
                    end
                    FOP_RET: begin
                        pop  = 1'b1;
                        pc_d = stk_empty ? pc_inc : stk_top;
                    end
                    FOP_LOOP: begin
                        arm  = 1'b1;
                        pc_d = pc_inc;
                    end
                    FOP_END: wait_d = 1'b1;
                    default: seq_step = 1'b1;
                endcase
            end
            if (seq_step) pc_d = loop_back ? loop_addr : pc_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            bub_q  <= 1'b0;
            wait_q <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            bub_q  <= bub_d;
            wait_q <= wait_d;
        end
    end

    assign fetch_addr_o = pc_q;
    assign nop_o        = bub_q | wait_q;

    // R3: a jump shows one bubble at its target
    a_r3_jump_bubble: assert property (@(posedge clk) disable iff (rst)
        (exec && op_i == FOP_JMP) |=> (nop_o && fetch_addr_o == $past(target_i)));
    // R3/R10: a bubble lasts a single cycle and holds the address
    a_r10_bubble_once: assert property (@(posedge clk) disable iff (rst)
        (bub_q && !wait_q) |=> (!nop_o && $stable(fetch_addr_o)));
    // R6: a return never inserts a bubble
    a_r6_ret_no_bubble: assert property (@(posedge clk) disable iff (rst)
        (exec && op_i == FOP_RET) |=> !nop_o);
    // R4: an untaken conditional steps by one without a bubble
    a_r4_untaken_step: assert property (@(posedge clk) disable iff (rst)
        (exec && is_cond && !taken && !loop_back) |=> (!nop_o && fetch_addr_o == $past(pc_inc)));
    // R9: the end wait holds until a frame pulse
    a_r9_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (wait_q && !frame_start_i) |=> (nop_o && $stable(fetch_addr_o)));
    // R9: a frame pulse in the wait restarts at address zero
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (rst)
        (wait_q && frame_start_i) |=> (!nop_o && fetch_addr_o == '0));
endmodule

// File: tb/seqctl_sequencer_tb.sv
`timescale 1ns/1ps
module seqctl_sequencer_tb;
    localparam int AW = 9;
    localparam int SZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    op_i;
    logic [AW-1:0] target_i;
    logic [4:0]    loop_cnt_i;
    logic          sgf_i, zrf_i, ovf_i, frame_start_i;
    logic [AW-1:0] fetch_addr_o;
    logic          nop_o, stack_err_o;

    always #2 clk = ~clk;

    seqctl_sequencer u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .target_i(target_i), .loop_cnt_i(loop_cnt_i),
        .sgf_i(sgf_i), .zrf_i(zrf_i), .ovf_i(ovf_i), .frame_start_i(frame_start_i),
        .fetch_addr_o(fetch_addr_o), .nop_o(nop_o), .stack_err_o(stack_err_o)
    );

    int n_cmp = 0, n_bad = 0;
    int p_op [SZ];
    int p_tg [SZ];
    int p_ct [SZ];

    // reference model state
    int m_pc, m_bub, m_wait, m_err, m_lact, m_lst, m_lend, m_lrem;
    int m_stk[$];
    string m_req;
    int flag_mode, fs_period, cyc;

    task automatic check_outputs();
        n_cmp++;
        if (fetch_addr_o !== AW'(m_pc) || nop_o !== (m_bub != 0 || m_wait != 0) ||
            stack_err_o !== (m_err != 0)) begin
            n_bad++;
            $display("FAIL %s: addr=%0d nop=%0b err=%0b expected addr=%0d nop=%0b err=%0b",
                     m_req, fetch_addr_o, nop_o, stack_err_o, m_pc,
                     (m_bub != 0 || m_wait != 0), (m_err != 0));
        end
    endtask

    function automatic bit taken_ref(int op, bit s, bit z, bit o);
        case (op)
            2: return s || z;
            3: return s;
            4: return !s;
            5: return !s && !z;
            6: return z;
            7: return !z;
            8: return o;
            9: return !o;
            default: return 0;
        endcase
    endfunction

    task automatic model_step(int op, int tg, int ct, bit s, bit z, bit o, bit fs);
        bit seq = 0;
        if (m_wait != 0) begin
            m_req = "R9";
            if (fs) begin m_pc = 0; m_wait = 0; m_lact = 0; end
        end else if (m_bub != 0) begin
            m_req = "R10";
            m_bub = 0;
        end else begin
            if (op >= 2 && op <= 9) begin
                m_req = "R4";
                if (taken_ref(op, s, z, o)) begin m_pc = tg; m_bub = 1; end
                else seq = 1;
            end else if (op == 1) begin
                m_req = "R3"; m_pc = tg; m_bub = 1;
            end else if (op == 10) begin
                m_req = "R5";
                if (m_stk.size() < 4) m_stk.push_back((m_pc + 1) % SZ);
                else begin m_err = 1; m_req = "R7"; end
                m_pc = tg; m_bub = 1;
            end else if (op == 11) begin
                m_req = "R6";
                if (m_stk.size() > 0) m_pc = m_stk.pop_back();
                else begin m_err = 1; m_req = "R7"; m_pc = (m_pc + 1) % SZ; end
            end else if (op == 12) begin
                m_req = "R8";
                m_lact = (ct > 1); m_lrem = (ct > 0) ? ct - 1 : 0;
                m_lst = (m_pc + 1) % SZ; m_lend = tg;
                m_pc = (m_pc + 1) % SZ;
            end else if (op == 13) begin
                m_req = "R9"; m_wait = 1;
            end else begin
                m_req = "R2"; seq = 1;
            end
            if (seq) begin
                if (m_lact != 0 && m_pc == m_lend) begin
                    m_req = "R8";
                    if (m_lrem > 0) begin m_pc = m_lst; m_lrem--; end
                    else begin m_lact = 0; m_pc = (m_pc + 1) % SZ; end
                end else m_pc = (m_pc + 1) % SZ;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_i = '0; target_i = '0; loop_cnt_i = '0;
        sgf_i = 0; zrf_i = 0; ovf_i = 0; frame_start_i = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_pc = 0; m_bub = 0; m_wait = 0; m_err = 0; m_lact = 0;
        m_lst = 0; m_lend = 0; m_lrem = 0; m_stk.delete();
        m_req = "R1"; cyc = 0;
        check_outputs();
    endtask

    task automatic run(int cycles);
        for (int k = 0; k < cycles; k++) begin
            bit s, z, o, fs;
            int op, tg, ct;
            if (k != 0) begin
                @(negedge clk);
                check_outputs();
            end
            cyc++;
            if (nop_o) begin
                op = $urandom % 16; tg = $urandom % SZ; ct = $urandom % 32;
            end else begin
                op = p_op[fetch_addr_o]; tg = p_tg[fetch_addr_o]; ct = p_ct[fetch_addr_o];
            end
            if (flag_mode != 0) begin s = $urandom % 2; z = $urandom % 2; o = $urandom % 2; end
            else begin s = 0; z = 0; o = 0; end
            fs = (cyc % fs_period) == 0;
            op_i = 4'(op); target_i = AW'(tg); loop_cnt_i = 5'(ct);
            sgf_i = s; zrf_i = z; ovf_i = o; frame_start_i = fs;
            model_step(op, tg, ct, s, z, o, fs);
        end
        @(negedge clk);
        check_outputs();
    endtask

    task automatic clear_prog();
        for (int a = 0; a < SZ; a++) begin p_op[a] = 0; p_tg[a] = 0; p_ct[a] = 0; end
    endtask

    task automatic put(int a, int op, int tg, int ct);
        p_op[a] = op; p_tg[a] = tg; p_ct[a] = ct;
    endtask

    initial begin
        rst = 1'b1;
        // Directed: nested call/return (R5, R6), loop (R8), untaken/taken condition (R4),
        // return on empty stack (R7), end wait and restart (R9).
        clear_prog();
        put(0, 10, 10, 0);
        put(1, 12, 3, 3);
        put(4, 1, 20, 0);
        put(10, 10, 12, 0);
        put(11, 11, 0, 0);
        put(12, 11, 0, 0);
        put(20, 8, 25, 0);
        put(21, 9, 25, 0);
        put(25, 11, 0, 0);
        put(26, 13, 0, 0);
        flag_mode = 0; fs_period = 50;
        do_reset();
        run(160);
        // Directed: stack overflow by five nested calls (R7), unused codes (R2)
        clear_prog();
        put(0, 10, 5, 0); put(5, 10, 10, 0); put(10, 10, 15, 0);
        put(15, 10, 20, 0); put(20, 10, 25, 0); put(25, 14, 0, 0);
        put(26, 15, 0, 0); put(27, 13, 0, 0);
        fs_period = 23;
        do_reset();
        run(120);
        // Random programs with random flags
        for (int r = 0; r < 6; r++) begin
            clear_prog();
            for (int a = 0; a < 64; a++) begin
                int v = $urandom % 22;
                put(a, (v < 8) ? 0 : v - 6, $urandom % 64, $urandom % 32);
            end
            flag_mode = 1; fs_period = 31 + 6 * r;
            do_reset();
            run(3000);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule